// File: doc/BRIEF.md
# Reversible Clock Fan-Out Router

This block steers a two-wire bus clock between one upstream port and a set of downstream ports (four by default). Each port is modelled digitally: the sampled line level comes in, and an open-drain pull-low enable goes out. A released line is assumed to float high.

In forward mode the upstream level is copied onto every enabled downstream port. In reverse mode the enabled downstream levels are wired-ANDed, and a low on any of them pulls the upstream line low. Disabled channels are neither driven nor listened to. The forward path is strictly one-way, so a downstream device cannot hold the upstream clock low to stretch it.

The channel mask and direction bit come from a control register. They are captured only on an update strobe, so the routing cannot change while a clock level is in progress. A small state machine holds the active routing. Its states are:
- `ST_ISOLATED`: nothing driven. This is the reset state.
- `ST_FORWARD`: upstream to downstream.
- `ST_REVERSE`: downstream to upstream.

On a strobe it takes one of these transitions:
- `T_LOAD_OFF`: empty mask, to `ST_ISOLATED`.
- `T_LOAD_FWD`: non-empty mask with the direction bit at 0, to `ST_FORWARD`.
- `T_LOAD_REV`: non-empty mask with the direction bit at 1, to `ST_REVERSE`.

Without a strobe it takes `T_HOLD` and stays where it is.

Top module: `clk_route_top`

## Requirements
- R1: In forward mode, for each enabled channel i, `dn_pull[i]` is 1 exactly when `up_level` is 0, in the same cycle (combinational path).
- R2: In reverse mode, `up_pull` is 1 exactly when at least one enabled channel has `dn_level[i]` = 0, and every `dn_pull` bit is 0.
- R3: A channel whose enable bit is 0 has `dn_pull[i]` = 0 in every mode, and its `dn_level[i]` has no effect on `up_pull`.
- R4: While reset is asserted and after reset, with no strobe since, all channels are disabled and the direction is forward. In that state every pull output is 0, whatever the input levels are.
- R5: In forward mode `up_pull` is always 0, whatever the downstream levels are (no clock stretching back upstream).
- R6: In reverse mode with an empty enable mask, `up_pull` is 0.
- R7: `cfg_en` and `cfg_rev` take effect only at a rising clock edge where `cfg_load` is 1, from that edge on. Without the strobe they have no effect.
- R8: Bit i of `cfg_en` enables channel i (bit 0 controls `dn_*[0]`). `cfg_rev` = 0 selects forward and `cfg_rev` = 1 selects reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe: capture `cfg_en` and `cfg_rev` |
| cfg_en | input | NCH | Channel enable mask |
| cfg_rev | input | 1 | Direction: 0 forward, 1 reverse |
| up_level | input | 1 | Sampled upstream clock line level |
| up_pull | output | 1 | Pull-low enable for the upstream clock line |
| dn_level | input | NCH | Sampled downstream clock line levels |
| dn_pull | output | NCH | Pull-low enables for the downstream clock lines |

## Verification
The hardest case to reach from the ports is a configuration that is presented but not yet loaded. To reach it, the stimulus holds a new mask and direction on the inputs for several cycles with the strobe low, and drives the lines so that the old and new routings would produce different pulls. The strobe is then raised between clock edges, so the outputs can be checked just before the capturing edge and again just after it.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;
    typedef enum logic [1:0] {
        ST_ISOLATED = 2'd0,
        ST_FORWARD  = 2'd1,
        ST_REVERSE  = 2'd2
    } route_state_e;
endpackage

// File: rtl/clkrt_ctrl.sv
module clkrt_ctrl
    import clkrt_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [NCH-1:0] en_in,
    input  logic           rev_in,
    output route_state_e   state,
    output logic [NCH-1:0] en_q
);
    route_state_e state_nxt;

    // Next-state selection: T_HOLD, T_LOAD_OFF, T_LOAD_FWD, T_LOAD_REV
    always_comb begin
        state_nxt = state;
        if (load) begin
            if (en_in == '0)
                state_nxt = ST_ISOLATED;
            else if (rev_in)
                state_nxt = ST_REVERSE;
            else
                state_nxt = ST_FORWARD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ISOLATED;
        else
            state <= state_nxt;
    end

    // Output register: active channel mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (load)
            en_q <= en_in;
    end

    // R7: without a strobe the routing does not move
    a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(en_q) && $stable(state)));

    // R8: a non-empty mask always leaves the isolated state
    a_r8_load_mask_state: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en_in != '0) |=> (state != ST_ISOLATED));
endmodule

// File: rtl/clkrt_fwd.sv
module clkrt_fwd #(
    parameter int NCH = 4
) (
    input  logic           active,
    input  logic [NCH-1:0] en,
    input  logic           up_level,
    output logic [NCH-1:0] dn_pull
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_comb dn_pull[g] = active & en[g] & ~up_level;
    end
endmodule

// File: rtl/clkrt_rev.sv
module clkrt_rev #(
    parameter int NCH = 4
) (
    input  logic           active,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] dn_level,
    output logic           up_pull
);
    logic [NCH-1:0] low_seen;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_comb low_seen[g] = en[g] & ~dn_level[g];
    end

    always_comb up_pull = active & (|low_seen);
endmodule

// File: rtl/clk_route_top.sv
module clk_route_top
    import clkrt_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [NCH-1:0] cfg_en,
    input  logic           cfg_rev,
    input  logic           up_level,
    output logic           up_pull,
    input  logic [NCH-1:0] dn_level,
    output logic [NCH-1:0] dn_pull
);
    route_state_e   state;
    logic [NCH-1:0] en_q;
    logic           fwd_on;
    logic           rev_on;

    clkrt_ctrl #(.NCH(NCH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .en_in  (cfg_en),
        .rev_in (cfg_rev),
        .state  (state),
        .en_q   (en_q)
    );

    always_comb begin
        fwd_on = 1'b0;
        rev_on = 1'b0;
        unique case (state)
            ST_ISOLATED: ;
            ST_FORWARD:  fwd_on = 1'b1;
            ST_REVERSE:  rev_on = 1'b1;
            default:     ;
        endcase
    end

    clkrt_fwd #(.NCH(NCH)) u_fwd (
        .active   (fwd_on),
        .en       (en_q),
        .up_level (up_level),
        .dn_pull  (dn_pull)
    );

    clkrt_rev #(.NCH(NCH)) u_rev (
        .active   (rev_on),
        .en       (en_q),
        .dn_level (dn_level),
        .up_pull  (up_pull)
    );

    // R3: disabled channels are never driven
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_pull & ~en_q) == '0);

    // R5: forward mode never drives upstream
    a_r5_no_back_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORWARD) |-> !up_pull);

    // R2: reverse mode never drives downstream
    a_r2_rev_dn_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REVERSE) |-> (dn_pull == '0));

    // R4: the isolated state releases every line
    a_r4_isolated_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISOLATED) |-> (!up_pull && dn_pull == '0));

    // R1: a pulled downstream line implies the upstream line is low
    a_r1_pull_follows_up: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_pull != '0) |-> !up_level);
endmodule

// File: tb/test_clk_route_top.sv
module test_clk_route_top;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_load = 1'b0;
    logic [NCH-1:0] cfg_en = '0;
    logic           cfg_rev = 1'b0;
    logic           up_level = 1'b1;
    logic           up_pull;
    logic [NCH-1:0] dn_level = '1;
    logic [NCH-1:0] dn_pull;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    clk_route_top #(.NCH(NCH)) i_clk_route_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_en   (cfg_en),
        .cfg_rev  (cfg_rev),
        .up_level (up_level),
        .up_pull  (up_pull),
        .dn_level (dn_level),
        .dn_pull  (dn_pull)
    );

    task automatic check(input string req, input logic [NCH:0] act, input logic [NCH:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got up_pull/dn_pull=%b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample a little later.
    task automatic drive(input logic up, input logic [NCH-1:0] dn);
        @(negedge clk);
        up_level = up;
        dn_level = dn;
        #2;
    endtask

    task automatic load_cfg(input logic [NCH-1:0] en, input logic rev);
        @(negedge clk);
        cfg_en   = en;
        cfg_rev  = rev;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset;
        up_level = 1'b0;
        dn_level = '0;
        #3;
        check("R4 in reset", {up_pull, dn_pull}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 4'b0000);
        check("R4 after reset", {up_pull, dn_pull}, '0);
    endtask

    task automatic t_forward;
        load_cfg(4'b1010, 1'b0);
        drive(1'b0, 4'b1111);
        check("R1 R8 fwd low", {up_pull, dn_pull}, {1'b0, 4'b1010});
        drive(1'b1, 4'b1111);
        check("R1 fwd high", {up_pull, dn_pull}, {1'b0, 4'b0000});
        drive(1'b1, 4'b0000);
        check("R5 fwd no stretch", {up_pull, dn_pull}, {1'b0, 4'b0000});
        load_cfg(4'b0001, 1'b0);
        drive(1'b0, 4'b0000);
        check("R3 R8 fwd ch0 only", {up_pull, dn_pull}, {1'b0, 4'b0001});
    endtask

    task automatic t_reverse;
        load_cfg(4'b0101, 1'b1);
        drive(1'b0, 4'b1111);
        check("R2 rev all high", {up_pull, dn_pull}, {1'b0, 4'b0000});
        drive(1'b1, 4'b1110);
        check("R2 rev ch0 low", {up_pull, dn_pull}, {1'b1, 4'b0000});
        drive(1'b1, 4'b1011);
        check("R2 rev ch2 low", {up_pull, dn_pull}, {1'b1, 4'b0000});
        drive(1'b1, 4'b0101);
        check("R3 rev disabled ignored", {up_pull, dn_pull}, {1'b0, 4'b0000});
    endtask

    task automatic t_rev_none;
        load_cfg(4'b0000, 1'b1);
        drive(1'b0, 4'b0000);
        check("R6 rev empty mask", {up_pull, dn_pull}, {1'b0, 4'b0000});
    endtask

    task automatic t_strobe;
        @(negedge clk);
        cfg_en  = 4'b1111;
        cfg_rev = 1'b0;
        repeat (3) @(negedge clk);
        drive(1'b0, 4'b0000);
        check("R7 no strobe", {up_pull, dn_pull}, {1'b0, 4'b0000});
        @(negedge clk);
        cfg_load = 1'b1;
        #2;
        check("R7 before edge", {up_pull, dn_pull}, {1'b0, 4'b0000});
        @(posedge clk);
        #2;
        cfg_load = 1'b0;
        check("R7 after edge", {up_pull, dn_pull}, {1'b0, 4'b1111});
    endtask

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_rev_none();
        t_strobe();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule